// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block is the receive half of an asynchronous serial port. It watches a single serial input line, finds the start of each character by oversampling the line, and shifts in eight data bits, least significant bit first. An optional parity bit follows, then one stop bit. Each finished character is written into a receive queue. The queue entry holds the data byte together with four error flags, so software that pops an entry gets the byte and the errors that belong to that byte in one read.

A mode input chooses between a 16-entry first-in first-out queue and a single holding register. Parity enable and even/odd selection are static configuration inputs. The oversampling strobe comes from an external rate generator. The read side pops one 12-bit entry for each cycle in which the read request is high. A line held low for more than one character time is reported as a break. It produces one zero entry and then blocks reception until the line has gone high again and a new start bit arrives.

Top module: `urx_tagged_rx`

## Requirements
- R1: Each queue entry is 12 bits wide. Bits 7..0 hold the data byte, bit 8 is the framing error, bit 9 is the parity error, bit 10 is the break flag and bit 11 is the overrun flag. The entry at the head of the queue is shown on `rd_data`.
- R2: A well-formed character (start 0, eight data bits LSB first, stop 1) is stored with its data byte and all four flags at zero.
- R3: When `par_en` is 1, a parity bit follows the data. With `par_even` = 1 the expected bit makes the count of ones across data and parity even; with `par_even` = 0 it makes that count odd. A mismatch sets bit 9. When `par_en` is 0, no parity bit is expected and bit 9 stays 0.
- R4: A character whose stop bit samples low, and that is not a break, is stored with bit 8 set.
- R5: If the line stays low from the start bit through the stop bit and for half a bit more, exactly one entry of value 0x400 is stored. It has data zero and only the break flag set.
- R6: After a break, no further entry is stored, however long the line stays low, until the line returns high and a new valid start bit is seen.
- R7: A character that completes while the queue is full is discarded. The next entry that is stored afterwards carries bit 11 set.
- R8: A low pulse that has ended by mid-bit (8 oversample ticks after the falling edge) is ignored and stores nothing.
- R9: With `fifo_en` = 1 the queue holds 16 entries and returns them in arrival order.
- R10: With `fifo_en` = 0 only one entry is held. A second character that arrives before the first has been read is an overrun under R7.
- R11: Popping an empty queue has no effect, and `rd_data` reads 0 while the queue is empty.
- R12: `rx_empty` is 1 exactly when no entry is held. `rx_full` is 1 when the held count has reached the capacity of the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial input line, idle high |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single holding register |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 12 | Head entry (flags and data), 0 when empty |
| rx_empty | output | 1 | No entry held |
| rx_full | output | 1 | Held count has reached capacity |

## Verification
The hardest case to reach from the ports is an overrun whose flag must appear on a later entry. The stimulus fills all 16 entries, then sends one more character that must vanish. It pops a single entry and sends a new character, and then drains the whole queue to confirm that only the last entry carries bit 11. The break lock needs a line held low for several character times, followed by a return to idle and a fresh frame. In holding mode the same overrun tagging is exercised with a capacity of one.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef struct packed {
    logic       oe;
    logic       be;
    logic       pe;
    logic       fe;
    logic [7:0] data;
  } urx_entry_t;

  localparam int unsigned ENTRY_W = $bits(urx_entry_t);

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP,
    FR_BRKCHK,
    FR_LOCK
  } fr_state_e;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/urx_framer.sv
module urx_framer
  import urx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       line,
  input  logic       par_en,
  input  logic       par_even,
  output logic       push,
  output urx_entry_t push_entry
);

  localparam int unsigned CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] MID_C  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF_C = CW'(OSR/2 - 1);

  fr_state_e     state_q, state_d;
  logic [CW-1:0] tick_q, tick_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    shift_q, shift_d;
  logic          par_q, par_d;
  logic          par_err;
  logic          all_low;

  // Parity bit expected for the byte held in the shifter
  always_comb begin
    par_err = 1'b0;
    if (par_en) begin
      par_err = (par_q != (par_even ? ^shift_q : ~^shift_q));
    end
    all_low = (shift_q == 8'h00) && (!par_en || !par_q);
  end

  always_comb begin
    state_d    = state_q;
    tick_d     = tick_q;
    bit_d      = bit_q;
    shift_d    = shift_q;
    par_d      = par_q;
    push       = 1'b0;
    push_entry = '0;

    unique case (state_q)
      FR_IDLE: begin
        tick_d = '0;
        if (!line) state_d = FR_START;
      end

      FR_START: begin
        if (os_tick) begin
          if (tick_q == MID_C) begin
            tick_d = '0;
            bit_d  = '0;
            state_d = line ? FR_IDLE : FR_DATA;
          end else begin
            tick_d = tick_q + 1'b1;
          end
        end
      end

      FR_DATA: begin
        if (os_tick) begin
          if (tick_q == LAST_C) begin
            tick_d  = '0;
            shift_d = {line, shift_q[7:1]};
            bit_d   = bit_q + 1'b1;
            if (bit_q == 3'd7) state_d = par_en ? FR_PAR : FR_STOP;
          end else begin
            tick_d = tick_q + 1'b1;
          end
        end
      end

      FR_PAR: begin
        if (os_tick) begin
          if (tick_q == LAST_C) begin
            tick_d  = '0;
            par_d   = line;
            state_d = FR_STOP;
          end else begin
            tick_d = tick_q + 1'b1;
          end
        end
      end

      FR_STOP: begin
        if (os_tick) begin
          if (tick_q == LAST_C) begin
            tick_d = '0;
            if (line) begin
              push            = 1'b1;
              push_entry.data = shift_q;
              push_entry.pe   = par_err;
              state_d         = FR_IDLE;
            end else if (all_low) begin
              state_d = FR_BRKCHK;
            end else begin
              push            = 1'b1;
              push_entry.data = shift_q;
              push_entry.pe   = par_err;
              push_entry.fe   = 1'b1;
              state_d         = FR_IDLE;
            end
          end else begin
            tick_d = tick_q + 1'b1;
          end
        end
      end

      FR_BRKCHK: begin
        if (line) begin
          push          = 1'b1;
          push_entry.fe = 1'b1;
          push_entry.pe = par_err;
          state_d       = FR_IDLE;
        end else if (os_tick) begin
          if (tick_q == HALF_C) begin
            push          = 1'b1;
            push_entry.be = 1'b1;
            state_d       = FR_LOCK;
          end else begin
            tick_d = tick_q + 1'b1;
          end
        end
      end

      FR_LOCK: begin
        tick_d = '0;
        if (line) state_d = FR_IDLE;
      end

      default: state_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      par_q   <= par_d;
    end
  end

endmodule

// File: rtl/urx_store.sv
module urx_store
  import urx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fifo_en,
  input  logic                 wr_en,
  input  urx_entry_t           wr_entry,
  input  logic                 rd_en,
  output logic [ENTRY_W-1:0]   rd_data,
  output logic                 empty,
  output logic                 full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   CAP_Q_C  = (AW+1)'(DEPTH);
  localparam logic [AW:0]   CAP_H_C  = (AW+1)'(1);
  localparam logic [AW-1:0] LAST_P_C = AW'(DEPTH - 1);

  urx_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          lost_q, lost_d;
  logic [AW:0]   cap;
  logic          do_pop, do_wr;
  urx_entry_t    wr_word;

  always_comb begin
    cap     = fifo_en ? CAP_Q_C : CAP_H_C;
    empty   = (cnt_q == '0);
    full    = (cnt_q >= cap);
    do_pop  = rd_en && !empty;
    do_wr   = wr_en && (!full || do_pop);
    wr_word    = wr_entry;
    wr_word.oe = lost_q;

    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    lost_d   = lost_q;

    if (do_wr) begin
      wr_ptr_d = (wr_ptr_q == LAST_P_C) ? '0 : wr_ptr_q + 1'b1;
      lost_d   = 1'b0;
    end else if (wr_en) begin
      lost_d   = 1'b1;
    end
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == LAST_P_C) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({do_wr, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase

    rd_data = empty ? '0 : mem_q[rd_ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      lost_q   <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      lost_q   <= lost_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wr_ptr_q] <= wr_word;
  end

endmodule

// File: rtl/urx_tagged_rx.sv
module urx_tagged_rx
  import urx_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rxd,
  input  logic        fifo_en,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        rd_en,
  output logic [11:0] rd_data,
  output logic        rx_empty,
  output logic        rx_full
);

  logic       rx_line;
  logic       fr_push;
  urx_entry_t fr_entry;

  urx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rx_line)
  );

  urx_framer #(.OSR(OSR)) i_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .line      (rx_line),
    .par_en    (par_en),
    .par_even  (par_even),
    .push      (fr_push),
    .push_entry(fr_entry)
  );

  urx_store #(.DEPTH(DEPTH)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .wr_en   (fr_push),
    .wr_entry(fr_entry),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (rx_empty),
    .full    (rx_full)
  );

endmodule

// File: rtl/urx_tagged_rx_chk.sv
module urx_tagged_rx_chk
  import urx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic       rx_empty,
  input logic       rx_full,
  input logic       fifo_en,
  input logic       par_en,
  input logic [11:0] rd_data,
  input logic       push,
  input urx_entry_t entry,
  input logic       line
);

  logic locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  locked_q <= 1'b0;
    else if (push && entry.be)   locked_q <= 1'b1;
    else if (line)               locked_q <= 1'b0;
  end

  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    push && entry.be |-> (entry.data == 8'h00) && !entry.fe && !entry.pe); // R5

  AST_BREAK_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> !push); // R6

  AST_NO_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    push && !par_en |-> !entry.pe); // R3

  AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && rd_en && !push |=> rx_empty); // R11

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> rd_data == 12'h000); // R11

  AST_HOLD_CAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && !rx_empty && $stable(fifo_en) |-> rx_full); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rd_en |=> !rx_empty); // R12

endmodule

bind urx_tagged_rx urx_tagged_rx_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .rx_empty(rx_empty),
  .rx_full (rx_full),
  .fifo_en (fifo_en),
  .par_en  (par_en),
  .rd_data (rd_data),
  .push    (fr_push),
  .entry   (fr_entry),
  .line    (rx_line)
);

// File: tb/test_urx_tagged_rx.sv
`timescale 1ns/1ps
module test_urx_tagged_rx;

  localparam int OSR = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        os_tick;
  logic        rxd;
  logic        fifo_en;
  logic        par_en;
  logic        par_even;
  logic        rd_en;
  logic [11:0] rd_data;
  logic        rx_empty;
  logic        rx_full;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  urx_tagged_rx i_urx_tagged_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .os_tick (os_tick),
    .rxd     (rxd),
    .fifo_en (fifo_en),
    .par_en  (par_en),
    .par_even(par_even),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .rx_empty(rx_empty),
    .rx_full (rx_full)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic hold_bits(input logic v, input int nbits);
    rxd = v;
    repeat (nbits * OSR) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par, input logic stop_v);
    logic pbit;
    hold_bits(1'b0, 1);
    for (int i = 0; i < 8; i++) hold_bits(d[i], 1);
    if (par_en) begin
      pbit = par_even ? ^d : ~^d;
      hold_bits(pbit ^ flip_par, 1);
    end
    hold_bits(stop_v, 1);
    hold_bits(1'b1, 1);
  endtask

  task automatic pop_expect(input string req, input logic [11:0] exp);
    check(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic fe_mode);
    rst_n = 1'b0; rxd = 1'b1; rd_en = 1'b0;
    fifo_en = fe_mode; par_en = 1'b0; par_even = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    check("R12 empty after reset", {11'd0, rx_empty}, 12'd1);
    check("R12 not full after reset", {11'd0, rx_full}, 12'd0);
    check("R11 zero when empty", rd_data, 12'h000);
  endtask

  task automatic t_good;
    send_frame(8'hA5, 0, 1'b1);
    send_frame(8'h3C, 0, 1'b1);
    send_frame(8'hFF, 0, 1'b1);
    pop_expect("R2 good 0xA5", 12'h0A5);
    pop_expect("R2 good 0x3C", 12'h03C);
    pop_expect("R1 good 0xFF", 12'h0FF);
    check("R12 empty after drain", {11'd0, rx_empty}, 12'd1);
  endtask

  task automatic t_parity;
    par_en = 1'b1; par_even = 1'b1;
    send_frame(8'h13, 0, 1'b1);
    send_frame(8'h13, 1, 1'b1);
    par_even = 1'b0;
    send_frame(8'h81, 0, 1'b1);
    send_frame(8'h81, 1, 1'b1);
    pop_expect("R3 even ok", 12'h013);
    pop_expect("R3 even bad", 12'h213);
    pop_expect("R3 odd ok", 12'h081);
    pop_expect("R3 odd bad", 12'h281);
    par_en = 1'b0; par_even = 1'b1;
  endtask

  task automatic t_framing;
    send_frame(8'h55, 0, 1'b0);
    pop_expect("R4 bad stop", 12'h155);
  endtask

  task automatic t_glitch;
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * OSR) @(negedge clk);
    check("R8 glitch ignored", {11'd0, rx_empty}, 12'd1);
    send_frame(8'h42, 0, 1'b1);
    pop_expect("R8 frame after glitch", 12'h042);
  endtask

  task automatic t_break;
    hold_bits(1'b0, 40);
    pop_expect("R5 single break entry", 12'h400);
    check("R6 nothing while low", {11'd0, rx_empty}, 12'd1);
    hold_bits(1'b1, 2);
    check("R6 nothing after idle", {11'd0, rx_empty}, 12'd1);
    send_frame(8'h6E, 0, 1'b1);
    pop_expect("R6 new start after break", 12'h06E);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 16; i++) send_frame(8'(i + 1), 0, 1'b1);
    check("R12 full at 16", {11'd0, rx_full}, 12'd1);
    send_frame(8'hEE, 0, 1'b1);
    pop_expect("R9 first out", 12'h001);
    send_frame(8'h77, 0, 1'b1);
    for (int i = 1; i < 16; i++) pop_expect("R9 order", 12'(i + 1));
    pop_expect("R7 overrun tag on next", 12'h877);
    check("R7 lost char gone", {11'd0, rx_empty}, 12'd1);
  endtask

  task automatic t_empty_read;
    pop_expect("R11 empty pop reads zero", 12'h000);
    check("R11 still empty", {11'd0, rx_empty}, 12'd1);
    send_frame(8'h21, 0, 1'b1);
    pop_expect("R11 pointers intact", 12'h021);
  endtask

  task automatic t_holding;
    do_reset(1'b0);
    send_frame(8'h11, 0, 1'b1);
    check("R10 full after one", {11'd0, rx_full}, 12'd1);
    send_frame(8'h22, 0, 1'b1);
    pop_expect("R10 first kept", 12'h011);
    send_frame(8'h33, 0, 1'b1);
    pop_expect("R10 overrun tagged", 12'h833);
    check("R10 empty", {11'd0, rx_empty}, 12'd1);
  endtask

  initial begin
    os_tick = 1'b1;
    t_reset();
    t_good();
    t_parity();
    t_framing();
    t_glitch();
    t_break();
    t_overrun();
    t_empty_read();
    t_holding();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule